// File: doc/BRIEF.md
# Reuse-Gated Assist Data Cache

This block is a small data cache made of two stores: a direct-mapped L1 array and a tiny fully-associative assist buffer beside it. Every L1 line carries a saturating access counter. Each accepted processor reference advances a window counter. When the window counter reaches the programmed window length, every line counter is cleared in the same cycle. A line whose counter reaches the programmed threshold on an L1 hit moves into the assist buffer. From then on the assist serves that line, so lines that conflict with it in the L1 can no longer push it out.

The processor presents a word address, a write flag and write data, and holds them with `req_valid` until `req_ready` rises. Hits complete in the cycle they are presented. A miss asks the next level for the line, which is one word here, and waits for the response. A dirty L1 line is written back whenever it is displaced. The threshold and the window length are configuration inputs and may change between references.

Top module: `reuse_assist_cache`

## Requirements
- R1: After reset both stores are empty. `req_ready`, `mem_req` and `mem_wb_valid` are low, and the first reference to any address misses.
- R2: A read returns the value of the last write to that address, or the next level's value if the address was never written.
- R3: On a miss `req_ready` is low in the request cycle. `mem_req` is high with `mem_req_addr` equal to the request address from the next cycle until `mem_rsp_valid`. The reference completes in the response cycle, with `req_ready` high and, for a read, the response data on `req_rdata`.
- R4: `mem_wb_valid` pulses only when a dirty line leaves the L1. `mem_wb_addr` and `mem_wb_data` carry that line's address and its latest written value. Replacing clean lines never causes a write-back.
- R5: A fill sets the line's count to one, and each accepted L1 hit adds one, saturating. An L1 hit whose new count is at least the threshold promotes the line.
- R6: In the cycle after a promoting hit, `req_ready` is low for any request. The promotion lasts exactly one cycle.
- R7: A promoted line leaves the L1. Later references to it hit with no next-level traffic, even after a conflicting line has been filled into its L1 set.
- R8: A threshold of zero disables promotion, so repeated L1 hits never stall.
- R9: A window length of zero never clears the counts. Otherwise, the accepted reference that brings the window counter to or past the window length clears all line counts and restarts the window. That reference's own hit still takes part in its promotion decision before the clear.
- R10: A promotion into a full assist displaces the least recently used entry, counting both promotions and assist hits as uses. The displaced line returns to its own L1 set with its dirty bit and a count of zero. A dirty line already in that set is written back first.
- R11: A reference that hits the L1 or the assist has `req_ready` and `req_hit` high in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | CW | Promotion threshold (0 disables promotion) |
| cfg_window | input | WW | Window length in accepted references (0 means no window) |
| req_valid | input | 1 | Processor request present |
| req_addr | input | AW | Word address |
| req_we | input | 1 | Write when high |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| req_hit | output | 1 | Request hit the L1 or the assist |
| req_rdata | output | DW | Read data, valid with req_ready |
| mem_req | output | 1 | Line fill request to next level |
| mem_req_addr | output | AW | Address to fill |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | DW | Fill data |
| mem_wb_valid | output | 1 | Write-back pulse to next level |
| mem_wb_addr | output | AW | Write-back address |
| mem_wb_data | output | DW | Write-back data |

## Verification
A wrong counter or window state can only show up as a stall cycle where none is expected, or a missing stall, one cycle after the hit that should or should not promote. The bench therefore counts the cycles each reference waits. A line placed in the wrong store, or with a lost dirty bit, shows up later as an unexpected fill request, a missing write-back or stale read data. This can surface many references after the fault, so every read and every write-back in the long random run is compared against a shadow copy of memory. A wrong replacement order is caught when the next displaced line returns to the L1 and its dirty neighbour is written back.

// File: rtl/reuse_assist_cache.sv
module reuse_assist_cache #(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int IW   = 3,
  parameter int ASZ  = 2,
  parameter int CW   = 3,
  parameter int WW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_thresh,
  input  logic [WW-1:0] cfg_window,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          req_hit,
  output logic [DW-1:0] req_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          mem_wb_valid,
  output logic [AW-1:0] mem_wb_addr,
  output logic [DW-1:0] mem_wb_data
);
  localparam int SETS = 1 << IW;
  localparam int TW   = AW - IW;
  localparam int AIW  = (ASZ > 1) ? $clog2(ASZ) : 1;
  localparam logic [CW-1:0]  CMAX = '1;
  localparam logic [AIW-1:0] AOLD = AIW'(ASZ - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROMO} st_t;
  st_t st;

  logic [SETS-1:0] l1_v, l1_d;
  logic [TW-1:0]   l1_tag  [SETS];
  logic [DW-1:0]   l1_data [SETS];
  logic [CW-1:0]   l1_cnt  [SETS];
  logic [ASZ-1:0]  as_v, as_d;
  logic [AW-1:0]   as_addr [ASZ];
  logic [DW-1:0]   as_data [ASZ];
  logic [AIW-1:0]  as_age  [ASZ];
  logic [AIW-1:0]  age_nx  [ASZ];
  logic [IW-1:0]   pidx;
  logic [WW-1:0]   wcnt;

  wire [IW-1:0] idx = req_addr[IW-1:0];
  wire [TW-1:0] tag = req_addr[AW-1:IW];

  logic [ASZ-1:0] ahit;
  logic [AIW-1:0] aidx, vsel, tk;
  always_comb begin
    aidx = '0;
    vsel = '0;
    for (int i = 0; i < ASZ; i++) begin
      ahit[i] = as_v[i] && as_addr[i] == req_addr;
      if (ahit[i]) aidx = AIW'(i);
      if (as_age[i] == AOLD) vsel = AIW'(i);
    end
    for (int i = ASZ - 1; i >= 0; i--)
      if (!as_v[i]) vsel = AIW'(i);
  end

  wire ahit_any = |ahit;
  wire lhit     = !ahit_any && l1_v[idx] && l1_tag[idx] == tag;
  wire idle_hit = st == S_IDLE && req_valid && (ahit_any || lhit);
  wire miss     = st == S_IDLE && req_valid && !ahit_any && !lhit;

  assign req_ready    = idle_hit || (st == S_FILL && mem_rsp_valid);
  assign req_hit      = idle_hit;
  assign req_rdata    = ahit_any ? as_data[aidx] : (st == S_FILL ? mem_rsp_data : l1_data[idx]);
  assign mem_req      = st == S_FILL;
  assign mem_req_addr = req_addr;

  wire [IW-1:0] rs     = as_addr[vsel][IW-1:0];
  wire          miss_wb  = miss && l1_v[idx] && l1_d[idx];
  wire          promo_wb = st == S_PROMO && as_v[vsel] && rs != pidx && l1_v[rs] && l1_d[rs];
  wire [IW-1:0] wb_set   = (st == S_PROMO) ? rs : idx;
  assign mem_wb_valid = miss_wb || promo_wb;
  assign mem_wb_addr  = {l1_tag[wb_set], wb_set};
  assign mem_wb_data  = l1_data[wb_set];

  wire [CW-1:0] ncnt     = (l1_cnt[idx] == CMAX) ? CMAX : l1_cnt[idx] + 1'b1;
  wire          promo_go = lhit && cfg_thresh != '0 && ncnt >= cfg_thresh;
  wire          acc      = req_valid && req_ready;
  wire [WW-1:0] wcnt_nx  = wcnt + 1'b1;
  wire          win_end  = cfg_window != '0 && wcnt_nx >= cfg_window;
  wire          touch    = (idle_hit && ahit_any) || st == S_PROMO;
  assign tk = (st == S_PROMO) ? vsel : aidx;

  always_comb
    for (int i = 0; i < ASZ; i++)
      age_nx[i] = (AIW'(i) == tk) ? '0 : (as_age[i] < as_age[tk] ? as_age[i] + 1'b1 : as_age[i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      l1_v <= '0;
      l1_d <= '0;
      as_v <= '0;
      as_d <= '0;
      pidx <= '0;
      wcnt <= '0;
      for (int i = 0; i < SETS; i++) l1_cnt[i] <= '0;
      for (int i = 0; i < ASZ; i++) as_age[i] <= AIW'(i);
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          if (ahit_any) begin
            if (req_we) begin
              as_data[aidx] <= req_wdata;
              as_d[aidx]    <= 1'b1;
            end
          end else if (lhit) begin
            if (req_we) begin
              l1_data[idx] <= req_wdata;
              l1_d[idx]    <= 1'b1;
            end
            l1_cnt[idx] <= ncnt;
            if (promo_go) begin
              st   <= S_PROMO;
              pidx <= idx;
            end
          end else begin
            st <= S_FILL;
          end
        end
        S_FILL: if (mem_rsp_valid) begin
          l1_v[idx]    <= 1'b1;
          l1_d[idx]    <= req_we;
          l1_tag[idx]  <= tag;
          l1_data[idx] <= req_we ? req_wdata : mem_rsp_data;
          l1_cnt[idx]  <= CW'(1);
          st <= S_IDLE;
        end
        default: begin
          as_v[vsel]    <= 1'b1;
          as_d[vsel]    <= l1_d[pidx];
          as_addr[vsel] <= {l1_tag[pidx], pidx};
          as_data[vsel] <= l1_data[pidx];
          l1_v[pidx]    <= 1'b0;
          if (as_v[vsel]) begin
            l1_v[rs]    <= 1'b1;
            l1_d[rs]    <= as_d[vsel];
            l1_tag[rs]  <= as_addr[vsel][AW-1:IW];
            l1_data[rs] <= as_data[vsel];
            l1_cnt[rs]  <= '0;
          end
          st <= S_IDLE;
        end
      endcase
      if (touch) as_age <= age_nx;
      if (acc) begin
        if (win_end) begin
          wcnt <= '0;
          for (int i = 0; i < SETS; i++) l1_cnt[i] <= '0;
        end else begin
          wcnt <= wcnt_nx;
        end
      end
    end
  end

  p_idle_reset_r1: assert property (@(posedge clk) $fell(rst_n) |=> !req_ready && !mem_req && !mem_wb_valid);
  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req);
  p_miss_enters_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> mem_req);
  p_wb_not_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> !req_ready);
  p_promo_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROMO |-> !req_ready && !mem_req);
  p_promo_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROMO |=> st == S_IDLE);
  p_one_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ahit_any |-> !(l1_v[idx] && l1_tag[idx] == tag));
  p_assist_unique_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ahit));
  p_no_promo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && cfg_thresh == '0 |=> st != S_PROMO);
endmodule

// File: tb/sim_reuse_assist_cache.sv
`timescale 1ns/1ps
module sim_reuse_assist_cache;
  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_thresh = 0;
  logic [7:0] cfg_window = 0;
  logic req_valid = 0, req_we = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, req_hit, mem_req, mem_wb_valid;
  logic [31:0] req_rdata, mem_wb_data;
  logic [7:0] mem_req_addr, mem_wb_addr;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  reuse_assist_cache u0 (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_window(cfg_window),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_hit(req_hit), .req_rdata(req_rdata),
    .mem_req(mem_req), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr),
    .mem_wb_data(mem_wb_data));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0, wb_count = 0;
  logic [7:0] wb_last = 0;
  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  int dly = 0;

  function automatic logic [31:0] init_val(int a);
    return (a * 32'h01010101) ^ 32'hA5A50000;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (mem_req && !mem_rsp_valid) begin
      if (dly == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data = mem[mem_req_addr];
      end else dly--;
    end else begin
      mem_rsp_valid = 0;
      dly = $urandom % 3;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && mem_wb_valid) begin
      chk(mem_wb_data == shadow[mem_wb_addr], "R4 wb data", mem_wb_data, shadow[mem_wb_addr]);
      mem[mem_wb_addr] = mem_wb_data;
      wb_count++;
      wb_last = mem_wb_addr;
    end
  end

  task automatic acc(input logic [7:0] a, input bit w, input logic [31:0] d,
                     output logic [31:0] rd, output int waits, output bit used);
    bit bad;
    bad = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = w; req_wdata = d;
    waits = 0; used = 0;
    #1;
    while (!req_ready && !bad) begin
      waits++;
      if (waits > 100) bad = 1;
      @(negedge clk);
      #1;
      if (mem_req) begin
        used = 1;
        chk(mem_req_addr == a, "R3 fill addr", mem_req_addr, a);
      end
    end
    if (bad) begin
      chk(0, "R3 request never accepted", waits, 0);
      rd = 0;
    end else rd = req_rdata;
    @(posedge clk);
    #1;
    req_valid = 0;
    if (w && !bad) shadow[a] = d;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string r, input int exp_waits,
                        input int exp_used);
    logic [31:0] rd; int wt; bit u;
    acc(a, 0, 0, rd, wt, u);
    chk(rd == shadow[a], {r, " data"}, rd, shadow[a]);
    if (exp_waits >= 0) chk(wt == exp_waits, {r, " wait cycles"}, wt, exp_waits);
    if (exp_used >= 0) chk(u == exp_used[0], {r, " next-level use"}, u, exp_used);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; int wt; bit u;
    acc(a, 1, d, rd, wt, u);
  endtask

  localparam logic [7:0] A = 8'h10, B = 8'h20, C = 8'h30, D = 8'h01, E = 8'h02;
  localparam logic [7:0] F = 8'h03, G = 8'h04, H = 8'h05, I = 8'h06;

  initial begin
    int wbc;
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    #1;
    chk(!req_ready && !mem_req && !mem_wb_valid, "R1 reset outputs",
        {req_ready, mem_req, mem_wb_valid}, 0);

    // R1 R3: first reference misses; R11 then hits at once; R8 thresh 0
    cfg_thresh = 0; cfg_window = 0;
    rd_chk(A, "R1 R3 cold miss", -1, 1);
    rd_chk(A, "R11 L1 hit", 0, 0);
    for (int k = 0; k < 5; k++) rd_chk(A, "R8 no promotion at zero", 0, 0);
    wbc = wb_count;
    rd_chk(B, "R4 clean replace", -1, 1);
    chk(wb_count == wbc, "R4 clean no wb", wb_count, wbc);

    // R5 R6 R7: threshold 3
    cfg_thresh = 3;
    rd_chk(A, "R5 fill count one", -1, 1);
    rd_chk(A, "R5 second touch", 0, 0);
    rd_chk(A, "R5 third touch promotes", 0, 0);
    rd_chk(A, "R6 promotion stall", 1, 0);
    wr(A, 32'hCAFE0001);
    rd_chk(B, "R7 conflict fill", -1, 1);
    rd_chk(A, "R7 R2 assist keeps line", 0, 0);

    // R10: LRU displacement
    rd_chk(D, "R10 D fill", -1, 1);
    rd_chk(D, "R10 D hit", 0, 0);
    rd_chk(D, "R10 D promotes", 0, 0);
    wr(C, 32'hBEEF0003);
    rd_chk(E, "R10 E fill", -1, 1);
    rd_chk(E, "R10 E hit", 0, 0);
    wbc = wb_count;
    rd_chk(E, "R10 E promotes", 0, 0);
    rd_chk(A, "R10 A back in L1", 1, 0);
    chk(wb_count == wbc + 1 && wb_last == C, "R10 dirty occupant written back", wb_last, C);
    rd_chk(C, "R2 R4 refetch after wb", -1, 1);
    rd_chk(D, "R10 D still in assist", 0, 0);

    // R9: window clears counts
    cfg_thresh = 2; cfg_window = 1;
    rd_chk(F, "R9 F fill", -1, 1);
    for (int k = 0; k < 3; k++) rd_chk(F, "R9 window 1 blocks promotion", 0, 0);
    cfg_window = 3;
    rd_chk(G, "R9 G fill", -1, 1);
    rd_chk(H, "R9 H fill", -1, 1);
    rd_chk(I, "R9 I fill closes window", -1, 1);
    rd_chk(G, "R9 G count restarted", 0, 0);
    rd_chk(G, "R9 G second hit promotes", 0, 0);
    rd_chk(G, "R9 R6 stall after promotion", 1, 0);

    // random mix, R2 R4
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      if (n % 100 == 0) begin
        cfg_thresh = 3'($urandom % 5);
        cfg_window = 8'($urandom % 8);
      end
      a = 8'($urandom % 48);
      if ($urandom % 3 == 0) wr(a, $urandom);
      else rd_chk(a, "R2 random read", -1, -1);
    end
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule